// File: doc/BRIEF.md
# Clock Generator Power-Management Controller

This block decides, on every cycle of the reference clock, which internal frequency sources of a multi-source clock generator may run and which clock outputs may drive their pads. It watches two asynchronous, active-low control pins. The first is an output-off pin. Depending on a configuration bit, it either powers the whole generator down or only releases the outputs. The second is a suspend pin. When suspend is configured, this pin stops a chosen set of phase-locked loops and a chosen set of outputs.

The configuration is latched while reset is held. It consists of the output-off meaning, the suspend enable, the two suspend masks and the source each output is derived from. A suspend mask that would stop a loop while leaving one of its outputs running is reported as illegal, and the suspend pin is then ignored.

Whenever a loop starts running again, the block issues a one-cycle relock strobe to that loop. An output is reported valid only when two things are true: the output is driven, and its source loop has reported lock after that restart. Disabled outputs are modelled as pulled low.

Top module: `clkgen_pwr_ctrl`

## Requirements
- R1: While reset is held, the configuration inputs are captured. In the first cycle after reset, all outputs drive and the oscillator and all loops run. Every loop gets a relock strobe in that same first cycle. All outputs are valid one cycle later if their loops report lock.
- R2: The pins pass through two synchronizer flops. A low on `pin_off_n` clears every `out_drive_en` bit two cycles after the pin changes.
- R3: With `cfg_pwr_down` = 1, a low on `pin_off_n` also clears `osc_run` and every `loop_run` bit.
- R4: With `cfg_pwr_down` = 0, a low on `pin_off_n` leaves `osc_run` and every `loop_run` bit at 1.
- R5: `relock_req[l]` is high for exactly one cycle after `loop_run[l]` rises, which is three cycles after the pin releases it.
- R6: An output is valid only when it is driven and its source's ready condition holds. For the oscillator (source code 0), that condition is `osc_run`. For loop k-1 (source code k), it is lock observed on a cycle after that loop's relock strobe. When lock drops, valid falls one cycle later.
- R7: With `cfg_susp_en` = 1 and a legal configuration, a low `pin_susp_n` stops the loops set in `cfg_susp_loops` and disables the outputs set in `cfg_susp_outs`. All other loops and outputs are left unchanged.
- R8: An output suspended on its own is only disabled; its source loop keeps running.
- R9: With `cfg_susp_en` = 0, `pin_susp_n` has no effect.
- R10: `cfg_illegal` is 1 in three cases. The first is when some output whose source is loop L is not in the output mask while L is in the loop mask. The second is when an output's source code exceeds the loop count. The third is when both occur. While `cfg_illegal` is 1, suspend has no effect.
- R11: `pad_out[j]` follows `clk_src[j]` while output j is driven and reads 0 while it is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| pin_off_n | input | 1 | Asynchronous output-off / power-down pin, active low |
| pin_susp_n | input | 1 | Asynchronous suspend pin, active low |
| cfg_pwr_down | input | 1 | 1: output-off pin powers down all sources; 0: outputs only |
| cfg_susp_en | input | 1 | Enables the suspend function of pin_susp_n |
| cfg_susp_loops | input | N_LOOP | Loops stopped by suspend |
| cfg_susp_outs | input | N_OUT | Outputs disabled by suspend |
| cfg_out_src | input | N_OUT*SRC_W | Source per output, SRC_W bits each (0 oscillator, k loop k-1) |
| loop_locked | input | N_LOOP | Lock status from each loop |
| clk_src | input | N_OUT | Modelled clock level for each output before gating |
| osc_run | output | 1 | Reference oscillator run enable |
| loop_run | output | N_LOOP | Per-loop run enable |
| relock_req | output | N_LOOP | One-cycle relock strobe per loop |
| out_drive_en | output | N_OUT | Per-output pad drive enable |
| pad_out | output | N_OUT | Modelled pad value (low when disabled) |
| out_valid | output | N_OUT | Output driven and its source settled |
| cfg_illegal | output | 1 | Captured suspend configuration breaks the dependency rule |

## Verification
The assertions check the following on every cycle:
- The two-cycle path from the output-off pin to the drive enables.
- That the output-off pin stops all sources in power-down mode, and that the oscillator keeps running in output-only mode.
- That relock strobes last one cycle and come only after a stopped cycle.
- That each valid flag rests on lock reported by its source loop.
- That an illegal configuration leaves suspend without effect.

Some behaviour can only be shown by the bench's scenarios, because it depends on particular masks and event orderings:
- That a stale high lock status is not accepted until after a restart.
- The exact suspend subsets.
- That an output suspended on its own leaves its loop running.
- That the suspend pin is ignored when suspend is not configured.

// File: rtl/clkgen_pwr_pkg.sv
// Shared types for the clock generator power-management controller.
// Assumes: source code 0 names the reference oscillator, code k names loop k-1.
package clkgen_pwr_pkg;

    localparam int SRC_OSC = 0;

    // Decoded, synchronized request state handed to the gating logic.
    typedef struct packed {
        logic out_off;   // output-off pin asserted
        logic pwr_down;  // output-off pin asserted and power-down configured
        logic susp_on;   // suspend pin asserted, configured and legal
    } pwr_state_t;

endpackage

// File: rtl/clkgen_pwr_sync.sv
// Two-flop synchronizer bank for asynchronous control pins.
// Assumes: pins are level signals held far longer than two clock cycles;
// flops reset to the inactive (high) level of the active-low pins.
module clkgen_pwr_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;

    // Two-stage capture of the asynchronous pins into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            q_sync <= '1;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end

endmodule

// File: rtl/clkgen_pwr_cfg.sv
// Configuration holder and suspend-mask legality check.
// Captures the configuration while reset is held, then freezes it.
// Flags a suspend set that stops a loop but leaves one of its outputs running,
// and any output source code beyond the number of loops.
module clkgen_pwr_cfg #(
    parameter int N_LOOP = 3,
    parameter int N_OUT  = 6,
    parameter int SRC_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_pwr_down,
    input  logic                   cfg_susp_en,
    input  logic [N_LOOP-1:0]      cfg_susp_loops,
    input  logic [N_OUT-1:0]       cfg_susp_outs,
    input  logic [N_OUT*SRC_W-1:0] cfg_out_src,
    output logic                   pwr_down_q,
    output logic                   susp_en_q,
    output logic [N_LOOP-1:0]      susp_loops_q,
    output logic [N_OUT-1:0]       susp_outs_q,
    output logic [N_OUT*SRC_W-1:0] out_src_q,
    output logic                   illegal
);

    // Load configuration during reset; hold it while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_down_q   <= cfg_pwr_down;
            susp_en_q    <= cfg_susp_en;
            susp_loops_q <= cfg_susp_loops;
            susp_outs_q  <= cfg_susp_outs;
            out_src_q    <= cfg_out_src;
        end
    end

    logic [N_OUT-1:0] out_bad;

    // Per-output dependency check against the captured masks.
    generate
        for (genvar j = 0; j < N_OUT; j++) begin : g_chk
            logic [SRC_W-1:0] src;
            assign src = out_src_q[j*SRC_W +: SRC_W];
            always_comb begin
                out_bad[j] = 1'b0;
                if (int'(src) > N_LOOP)
                    out_bad[j] = 1'b1;
                else if (int'(src) != 0)
                    out_bad[j] = susp_loops_q[int'(src) - 1] && !susp_outs_q[j];
            end
        end
    endgenerate

    assign illegal = |out_bad;

endmodule

// File: rtl/clkgen_pwr_loop.sv
// Per-loop run control: run enable, relock strobe and settled flag.
// Assumes: lock status may stay high while a loop is stopped, so lock is only
// accepted on a cycle after the loop has been running for one full cycle.
module clkgen_pwr_loop #(
    parameter int N_LOOP = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  clkgen_pwr_pkg::pwr_state_t st,
    input  logic [N_LOOP-1:0]         susp_loops,
    input  logic [N_LOOP-1:0]         loop_locked,
    output logic [N_LOOP-1:0]         loop_run,
    output logic [N_LOOP-1:0]         relock_req,
    output logic [N_LOOP-1:0]         loop_ready
);

    generate
        for (genvar l = 0; l < N_LOOP; l++) begin : g_loop
            logic run_q;

            assign loop_run[l] = !st.pwr_down && !(st.susp_on && susp_loops[l]);

            // Track restarts, strobe relock, and accept lock only after restart.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q         <= 1'b0;
                    relock_req[l] <= 1'b0;
                    loop_ready[l] <= 1'b0;
                end else begin
                    run_q         <= loop_run[l];
                    relock_req[l] <= loop_run[l] && !run_q;
                    loop_ready[l] <= loop_run[l] && run_q && loop_locked[l];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/clkgen_pwr_ctrl.sv
// Top of the clock generator power-management controller.
// Synchronizes the output-off and suspend pins, applies the captured
// configuration, and produces source run enables, output drive enables,
// modelled pad values, per-output valid flags and relock strobes.
// Assumes: clk is the free-running reference clock seen by this logic.
module clkgen_pwr_ctrl #(
    parameter int N_LOOP = 3,
    parameter int N_OUT  = 6,
    parameter int SRC_W  = $clog2(N_LOOP + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pin_off_n,
    input  logic                   pin_susp_n,
    input  logic                   cfg_pwr_down,
    input  logic                   cfg_susp_en,
    input  logic [N_LOOP-1:0]      cfg_susp_loops,
    input  logic [N_OUT-1:0]       cfg_susp_outs,
    input  logic [N_OUT*SRC_W-1:0] cfg_out_src,
    input  logic [N_LOOP-1:0]      loop_locked,
    input  logic [N_OUT-1:0]       clk_src,
    output logic                   osc_run,
    output logic [N_LOOP-1:0]      loop_run,
    output logic [N_LOOP-1:0]      relock_req,
    output logic [N_OUT-1:0]       out_drive_en,
    output logic [N_OUT-1:0]       pad_out,
    output logic [N_OUT-1:0]       out_valid,
    output logic                   cfg_illegal
);
    import clkgen_pwr_pkg::*;

    localparam int N_PINS = 2;

    logic [N_PINS-1:0]      pins_s;
    logic                   off_n_s;
    logic                   susp_n_s;
    logic                   cfg_pwr_down_q;
    logic                   cfg_susp_en_q;
    logic [N_LOOP-1:0]      cfg_susp_loops_q;
    logic [N_OUT-1:0]       cfg_susp_outs_q;
    logic [N_OUT*SRC_W-1:0] cfg_out_src_q;
    logic [N_LOOP-1:0]      loop_ready;
    pwr_state_t             st;

    clkgen_pwr_sync #(.W(N_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({pin_susp_n, pin_off_n}),
        .q_sync  (pins_s)
    );

    assign off_n_s  = pins_s[0];
    assign susp_n_s = pins_s[1];

    clkgen_pwr_cfg #(.N_LOOP(N_LOOP), .N_OUT(N_OUT), .SRC_W(SRC_W)) u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_pwr_down   (cfg_pwr_down),
        .cfg_susp_en    (cfg_susp_en),
        .cfg_susp_loops (cfg_susp_loops),
        .cfg_susp_outs  (cfg_susp_outs),
        .cfg_out_src    (cfg_out_src),
        .pwr_down_q     (cfg_pwr_down_q),
        .susp_en_q      (cfg_susp_en_q),
        .susp_loops_q   (cfg_susp_loops_q),
        .susp_outs_q    (cfg_susp_outs_q),
        .out_src_q      (cfg_out_src_q),
        .illegal        (cfg_illegal)
    );

    // Decode synchronized pins against the captured configuration.
    always_comb begin
        st.out_off  = !off_n_s;
        st.pwr_down = !off_n_s && cfg_pwr_down_q;
        st.susp_on  = !susp_n_s && cfg_susp_en_q && !cfg_illegal;
    end

    assign osc_run = !st.pwr_down;

    clkgen_pwr_loop #(.N_LOOP(N_LOOP)) u_loop (
        .clk         (clk),
        .rst_n       (rst_n),
        .st          (st),
        .susp_loops  (cfg_susp_loops_q),
        .loop_locked (loop_locked),
        .loop_run    (loop_run),
        .relock_req  (relock_req),
        .loop_ready  (loop_ready)
    );

    // Per-output gating, pad model and validity.
    generate
        for (genvar j = 0; j < N_OUT; j++) begin : g_out
            logic [SRC_W-1:0] src;
            logic             src_ok;
            assign src = cfg_out_src_q[j*SRC_W +: SRC_W];
            always_comb begin
                if (int'(src) == SRC_OSC)
                    src_ok = osc_run;
                else if (int'(src) <= N_LOOP)
                    src_ok = loop_ready[int'(src) - 1];
                else
                    src_ok = 1'b0;
            end
            assign out_drive_en[j] = !st.out_off && !(st.susp_on && cfg_susp_outs_q[j]);
            assign pad_out[j]      = clk_src[j] && out_drive_en[j];
            assign out_valid[j]    = out_drive_en[j] && src_ok;
        end
    endgenerate

endmodule

// File: rtl/clkgen_pwr_ctrl_chk.sv
// Checker for clkgen_pwr_ctrl, attached by bind below.
// Assumes: pins reach the enables through exactly two flops.
module clkgen_pwr_ctrl_chk #(
    parameter int N_LOOP = 3,
    parameter int N_OUT  = 6,
    parameter int SRC_W  = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pin_off_n,
    input logic                   osc_run,
    input logic [N_LOOP-1:0]      loop_run,
    input logic [N_LOOP-1:0]      relock_req,
    input logic [N_LOOP-1:0]      loop_locked,
    input logic [N_OUT-1:0]       out_drive_en,
    input logic [N_OUT-1:0]       out_valid,
    input logic                   cfg_illegal,
    input logic                   cfg_pwr_down_q,
    input logic [N_OUT*SRC_W-1:0] cfg_out_src_q
);

    logic [1:0] age;
    logic       alive;

    // Count edges since reset so $past never reaches into reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        age <= 2'd0;
        else if (age != 3) age <= age + 2'd1;
    end
    assign alive = (age == 2'd3);

    // R2
    a_r2_off_pin_drops_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (alive && !$past(pin_off_n, 2)) |-> (out_drive_en == '0));

    // R3
    a_r3_power_down_stops_all: assert property (@(posedge clk) disable iff (!rst_n)
        (alive && cfg_pwr_down_q && !$past(pin_off_n, 2)) |-> (!osc_run && loop_run == '0));

    // R4
    a_r4_outputs_only_keeps_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (alive && !cfg_pwr_down_q) |-> osc_run);

    // R5
    a_r5_relock_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (relock_req != '0) |=> ((relock_req & $past(relock_req)) == '0));

    // R5
    a_r5_relock_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (alive && relock_req != '0) |-> ((relock_req & $past(loop_run, 2)) == '0));

    // R10
    a_r10_illegal_blocks_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (alive && cfg_illegal && $past(pin_off_n, 2)) |-> (loop_run == '1 && out_drive_en == '1));

    // R6: a valid loop-fed output rests on lock seen on the previous cycle.
    generate
        for (genvar j = 0; j < N_OUT; j++) begin : g_v
            logic [SRC_W-1:0] src;
            logic             lk;
            assign src = cfg_out_src_q[j*SRC_W +: SRC_W];
            assign lk  = (int'(src) != 0 && int'(src) <= N_LOOP) ? loop_locked[int'(src) - 1] : 1'b1;
            a_r6_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
                (alive && out_valid[j] && int'(src) != 0) |-> $past(lk));
        end
    endgenerate

endmodule

bind clkgen_pwr_ctrl clkgen_pwr_ctrl_chk #(.N_LOOP(N_LOOP), .N_OUT(N_OUT), .SRC_W(SRC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pin_off_n      (pin_off_n),
    .osc_run        (osc_run),
    .loop_run       (loop_run),
    .relock_req     (relock_req),
    .loop_locked    (loop_locked),
    .out_drive_en   (out_drive_en),
    .out_valid      (out_valid),
    .cfg_illegal    (cfg_illegal),
    .cfg_pwr_down_q (cfg_pwr_down_q),
    .cfg_out_src_q  (cfg_out_src_q)
);

// File: tb/tb_clkgen_pwr_ctrl.sv
// Scoreboard bench: stimulus tasks queue expected values with a due cycle,
// a monitor at each falling edge compares the items that fall due.
module tb_clkgen_pwr_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 3;
    localparam int NO = 6;
    localparam int SW = 2;
    // out0 osc, out1 loop0, out2 loop1, out3 loop2, out4 loop2, out5 loop0
    localparam logic [NO*SW-1:0] SRC_MAP = 12'b01_11_11_10_01_00;

    localparam int S_DRV = 0, S_PAD = 1, S_OSC = 2, S_RUN = 3,
                   S_RLK = 4, S_VAL = 5, S_ILL = 6;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_off_n = 1'b1, pin_susp_n = 1'b1;
    logic cfg_pwr_down = 1'b1, cfg_susp_en = 1'b0;
    logic [NL-1:0] cfg_susp_loops = '0;
    logic [NO-1:0] cfg_susp_outs = '0;
    logic [NO*SW-1:0] cfg_out_src = SRC_MAP;
    logic [NL-1:0] loop_locked = '1;
    logic [NO-1:0] clk_src = '1;
    logic osc_run, cfg_illegal;
    logic [NL-1:0] loop_run, relock_req;
    logic [NO-1:0] out_drive_en, pad_out, out_valid;

    item_t q[$];
    int ncnt = 0;
    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgen_pwr_ctrl #(.N_LOOP(NL), .N_OUT(NO), .SRC_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .pin_off_n(pin_off_n), .pin_susp_n(pin_susp_n),
        .cfg_pwr_down(cfg_pwr_down), .cfg_susp_en(cfg_susp_en),
        .cfg_susp_loops(cfg_susp_loops), .cfg_susp_outs(cfg_susp_outs),
        .cfg_out_src(cfg_out_src), .loop_locked(loop_locked), .clk_src(clk_src),
        .osc_run(osc_run), .loop_run(loop_run), .relock_req(relock_req),
        .out_drive_en(out_drive_en), .pad_out(pad_out), .out_valid(out_valid),
        .cfg_illegal(cfg_illegal)
    );

    function automatic logic [31:0] observe(int sel);
        case (sel)
            S_DRV:   return 32'(out_drive_en);
            S_PAD:   return 32'(pad_out);
            S_OSC:   return 32'(osc_run);
            S_RUN:   return 32'(loop_run);
            S_RLK:   return 32'(relock_req);
            S_VAL:   return 32'(out_valid);
            default: return 32'(cfg_illegal);
        endcase
    endfunction

    // Monitor: compare every item falling due on this falling edge.
    always @(negedge clk) begin
        item_t keep[$];
        ncnt++;
        keep = {};
        foreach (q[i]) begin
            if (q[i].due == ncnt) begin
                logic [31:0] act;
                act = observe(q[i].sel);
                n_cmp++;
                if (act !== q[i].exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h",
                             q[i].req, q[i].sel, ncnt, act, q[i].exp);
                end
            end else begin
                keep.push_back(q[i]);
            end
        end
        q = keep;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_at(int dly, int sel, logic [31:0] v, string req);
        item_t it;
        it.due = ncnt + dly; it.sel = sel; it.exp = v; it.req = req;
        q.push_back(it);
    endtask

    task automatic do_reset(logic pd, logic se, logic [NL-1:0] lm, logic [NO-1:0] om, logic ill);
        tick(1);
        rst_n = 1'b0; pin_off_n = 1'b1; pin_susp_n = 1'b1;
        loop_locked = '1; clk_src = '1;
        cfg_pwr_down = pd; cfg_susp_en = se; cfg_susp_loops = lm; cfg_susp_outs = om;
        tick(3);
        rst_n = 1'b1;
        expect_at(1, S_DRV, 32'h3F, "R1");
        expect_at(1, S_OSC, 32'h1,  "R1");
        expect_at(1, S_RUN, 32'h7,  "R1");
        expect_at(1, S_RLK, 32'h7,  "R1");
        expect_at(1, S_ILL, 32'(ill), "R10");
        expect_at(2, S_RLK, 32'h0,  "R5");
        expect_at(2, S_VAL, 32'h3F, "R1");
        tick(4);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        // Scenario A: power-down meaning, legal suspend of loop2 with out3/out4.
        do_reset(1'b1, 1'b1, 3'b100, 6'b011000, 1'b0);

        // R2/R3/R11: output-off pin low powers everything down.
        pin_off_n = 1'b0;
        expect_at(1, S_DRV, 32'h3F, "R2");
        expect_at(2, S_DRV, 32'h00, "R2");
        expect_at(2, S_PAD, 32'h00, "R11");
        expect_at(2, S_OSC, 32'h0,  "R3");
        expect_at(2, S_RUN, 32'h0,  "R3");
        expect_at(2, S_VAL, 32'h00, "R6");
        tick(5);
        // R5/R6: release; lock stays high but is not trusted until after relock.
        pin_off_n = 1'b1;
        expect_at(2, S_DRV, 32'h3F, "R2");
        expect_at(2, S_RUN, 32'h7,  "R5");
        expect_at(2, S_VAL, 32'h01, "R6");
        expect_at(2, S_RLK, 32'h0,  "R5");
        expect_at(3, S_RLK, 32'h7,  "R5");
        expect_at(4, S_RLK, 32'h0,  "R5");
        expect_at(4, S_VAL, 32'h3F, "R6");
        tick(6);

        // R7: suspend stops loop2 and disables out3/out4 only.
        pin_susp_n = 1'b0;
        expect_at(2, S_RUN, 32'h3,  "R7");
        expect_at(2, S_DRV, 32'h27, "R7");
        expect_at(2, S_PAD, 32'h27, "R11");
        expect_at(2, S_OSC, 32'h1,  "R7");
        tick(5);
        pin_susp_n = 1'b1;
        expect_at(3, S_RLK, 32'h4,  "R5");
        expect_at(4, S_VAL, 32'h3F, "R6");
        tick(6);

        // R6: lock drop on loop0 invalidates out1/out5 one cycle later.
        loop_locked = 3'b110;
        expect_at(1, S_VAL, 32'h1D, "R6");
        expect_at(1, S_DRV, 32'h3F, "R6");
        tick(3);
        loop_locked = 3'b111;
        expect_at(1, S_VAL, 32'h3F, "R6");
        tick(3);

        // R11: pad follows source pattern while driven.
        clk_src = 6'b101010;
        expect_at(1, S_PAD, 32'h2A, "R11");
        tick(2);
        clk_src = 6'b010101;
        expect_at(1, S_PAD, 32'h15, "R11");
        tick(2);

        // Scenario E: outputs-only meaning, suspend not configured.
        do_reset(1'b0, 1'b0, 3'b111, 6'b111111, 1'b0);
        pin_off_n = 1'b0;
        expect_at(2, S_DRV, 32'h00, "R2");
        expect_at(2, S_PAD, 32'h00, "R11");
        expect_at(2, S_OSC, 32'h1,  "R4");
        expect_at(2, S_RUN, 32'h7,  "R4");
        tick(5);
        pin_off_n = 1'b1;
        expect_at(3, S_RLK, 32'h0,  "R4");
        expect_at(3, S_VAL, 32'h3F, "R4");
        tick(6);
        // R9: suspend pin ignored when not configured.
        pin_susp_n = 1'b0;
        expect_at(2, S_RUN, 32'h7,  "R9");
        expect_at(2, S_DRV, 32'h3F, "R9");
        expect_at(3, S_RLK, 32'h0,  "R9");
        tick(5);
        pin_susp_n = 1'b1;
        tick(3);

        // Scenario F: loop0 suspended but out5 (fed by loop0) left out -> illegal.
        do_reset(1'b1, 1'b1, 3'b001, 6'b000010, 1'b1);
        pin_susp_n = 1'b0;
        expect_at(2, S_RUN, 32'h7,  "R10");
        expect_at(2, S_DRV, 32'h3F, "R10");
        expect_at(2, S_ILL, 32'h1,  "R10");
        tick(5);
        pin_susp_n = 1'b1;
        tick(3);

        // Scenario G: suspend an output alone; its loop keeps running.
        do_reset(1'b1, 1'b1, 3'b000, 6'b000100, 1'b0);
        pin_susp_n = 1'b0;
        expect_at(2, S_DRV, 32'h3B, "R8");
        expect_at(2, S_RUN, 32'h7,  "R8");
        expect_at(2, S_VAL, 32'h3B, "R8");
        expect_at(2, S_PAD, 32'h3B, "R11");
        tick(5);
        pin_susp_n = 1'b1;
        expect_at(2, S_DRV, 32'h3F, "R8");
        expect_at(3, S_RLK, 32'h0,  "R8");
        tick(6);

        tick(4);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard actual=%0d pending expected=0", q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule